// File: doc/BRIEF.md
# Hub Port Change Interrupt Logic

This block collects the per-port event pulses reported by a downstream hub repeater and turns them into a single interrupt request for the processor. Every downstream port reports three kinds of event: a change of attachment (device plugged in or removed), detection of babble, and detection of resume signalling. Each event kind passes through its own qualifying rule before it may set the shared pending flag.

Babble and resume pass only while the port's enable bit is high. An attachment change passes regardless of the enable bit, but is dropped while the port is in forced-drive mode, where the port lines are held by firmware and not by the serial engine. All qualified events of all ports merge into one pending flag. A two-state machine holds the flag: `ST_IDLE` (nothing waiting) and `ST_PENDING` (an event is waiting for service). The transition `T_RAISE` (ST_IDLE to ST_PENDING) fires on any qualified event. `T_CLEAR` (ST_PENDING to ST_IDLE) fires on an acknowledge pulse in a cycle with no qualified event. `T_HOLD` (ST_PENDING stays) covers every other cycle in ST_PENDING, including acknowledge together with a new event. `T_REST` (ST_IDLE stays) covers ST_IDLE with no event, acknowledge or not. The request output is the pending flag gated by a global enable.

Top module: `hub_change_irq`

## Requirements
- R1: After reset the pending flag `pending_o` and the request `irq_o` are 0.
- R2: A babble pulse on port p while `port_en_i[p]` is 1 sets `pending_o` to 1 on the clock edge that samples the pulse.
- R3: A babble pulse on port p while `port_en_i[p]` is 0 leaves `pending_o` unchanged.
- R4: A resume pulse on port p sets `pending_o` only while `port_en_i[p]` is 1; with the bit 0 it leaves `pending_o` unchanged.
- R5: An attachment-change pulse on port p while `forced_i[p]` is 0 sets `pending_o`, whatever the value of `port_en_i[p]`.
- R6: An attachment-change pulse on port p while `forced_i[p]` is 1 leaves `pending_o` unchanged.
- R7: Qualified events from any port and any event kind, alone or several at once, all set the same single `pending_o`.
- R8: Once set, `pending_o` stays 1 until an `ack_i` pulse; an `ack_i` pulse in a cycle with no qualified event clears it on that edge, and `ack_i` while the flag is 0 has no effect.
- R9: When a qualified event and `ack_i` occur in the same cycle, `pending_o` is 1 after that edge.
- R10: `irq_o` is 1 exactly when `pending_o` is 1 and `global_en_i` is 1; dropping `global_en_i` does not clear `pending_o`, and raising it again brings the request back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conn_chg_i | input | NPORTS | One-cycle attachment-change pulse per port |
| babble_i | input | NPORTS | One-cycle babble pulse per port |
| resume_i | input | NPORTS | One-cycle resume pulse per port |
| port_en_i | input | NPORTS | Per-port enable for babble and resume |
| forced_i | input | NPORTS | Per-port forced-drive flag, suppresses attachment change |
| global_en_i | input | 1 | Global gate on the request output |
| ack_i | input | 1 | One-cycle acknowledge pulse |
| pending_o | output | 1 | Pending flag |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
An event or acknowledge sampled at a rising edge shows on `pending_o` one cycle later, right after that edge, because only the state register lies on the path; `irq_o` follows `global_en_i` in the same cycle with no register. The bench drives every input just after a falling edge, lets the model update at the rising edge from the same sampled values, and compares both outputs at the next falling edge, so every result is read in the cycle it is due. Directed cycles cover each gating rule on each event kind, the forced and enabled corners, acknowledge collisions and the global gate, then a long pseudo-random run keeps the model and the design in lockstep.

// File: rtl/hub_irq_pkg.sv
package hub_irq_pkg;

    // Pending-flag machine states
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PENDING = 1'b1
    } pend_state_t;

endpackage

// File: rtl/hub_port_qual.sv
// Per-port event qualification: each event kind has its own gating rule.
module hub_port_qual #(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] conn_chg_i,
    input  logic [NPORTS-1:0] babble_i,
    input  logic [NPORTS-1:0] resume_i,
    input  logic [NPORTS-1:0] port_en_i,
    input  logic [NPORTS-1:0] forced_i,
    output logic [NPORTS-1:0] hit_o
);

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic line_evt;
        logic attach_evt;

        // babble and resume share the enable gate
        assign line_evt   = port_en_i[p] & (babble_i[p] | resume_i[p]);
        // attachment change is dropped while firmware forces the port
        assign attach_evt = conn_chg_i[p] & ~forced_i[p];
        assign hit_o[p]   = line_evt | attach_evt;

        // disabled port with only babble/resume must not qualify
        assert_masked_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!port_en_i[p] && !conn_chg_i[p]) |-> !hit_o[p]);

        // forced port with only an attachment change must not qualify
        assert_forced_attach_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (forced_i[p] && !babble_i[p] && !resume_i[p]) |-> !hit_o[p]);
    end

endmodule

// File: rtl/hub_evt_merge.sv
// Folds the per-port qualified hits into one event strobe.
module hub_evt_merge #(
    parameter int NPORTS = 4
) (
    input  logic [NPORTS-1:0] hit_i,
    output logic              any_o
);

    assign any_o = |hit_i;

endmodule

// File: rtl/hub_pend_fsm.sv
// Two-state pending machine: raise on event, clear on acknowledge.
module hub_pend_fsm
    import hub_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic ack_i,
    output logic pending_o
);

    pend_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (evt_i) state_d = ST_PENDING;           // T_RAISE
            ST_PENDING: if (ack_i && !evt_i) state_d = ST_IDLE;    // T_CLEAR
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pending_o = (state_q == ST_PENDING);
    end

    assert_evt_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> pending_o);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !evt_i) |=> !pending_o);

    assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !ack_i) |=> pending_o);

    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending_o && !evt_i) |=> !pending_o);

    assert_collision_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && ack_i) |=> pending_o);

endmodule

// File: rtl/hub_change_irq.sv
module hub_change_irq #(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] conn_chg_i,
    input  logic [NPORTS-1:0] babble_i,
    input  logic [NPORTS-1:0] resume_i,
    input  logic [NPORTS-1:0] port_en_i,
    input  logic [NPORTS-1:0] forced_i,
    input  logic              global_en_i,
    input  logic              ack_i,
    output logic              pending_o,
    output logic              irq_o
);

    logic [NPORTS-1:0] hit;
    logic              any_hit;

    hub_port_qual #(.NPORTS(NPORTS)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .conn_chg_i(conn_chg_i),
        .babble_i  (babble_i),
        .resume_i  (resume_i),
        .port_en_i (port_en_i),
        .forced_i  (forced_i),
        .hit_o     (hit)
    );

    hub_evt_merge #(.NPORTS(NPORTS)) u_merge (
        .hit_i(hit),
        .any_o(any_hit)
    );

    hub_pend_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (any_hit),
        .ack_i    (ack_i),
        .pending_o(pending_o)
    );

    assign irq_o = pending_o & global_en_i;

    // a gated-off request still keeps its pending event
    assert_gate_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!global_en_i && pending_o && !ack_i) |=> pending_o);

    assert_gate_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !global_en_i |-> !irq_o);

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> !pending_o);

endmodule

// File: tb/hub_change_irq_tb.sv
module hub_change_irq_tb;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] conn = '0, bab = '0, res = '0, en = '0, frc = '0;
    logic          gen = 1'b0, ack = 1'b0;
    logic          pending, irq;

    int n_chk = 0, n_fail = 0;
    bit model_pend = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hub_change_irq #(.NPORTS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .conn_chg_i(conn), .babble_i(bab), .resume_i(res),
        .port_en_i(en), .forced_i(frc),
        .global_en_i(gen), .ack_i(ack),
        .pending_o(pending), .irq_o(irq)
    );

    // behavioural reference, updated from the values sampled at each edge
    always @(posedge clk) begin
        bit hit;
        hit = 0;
        for (int p = 0; p < NP; p++) begin
            if (en[p] && (bab[p] || res[p])) hit = 1;
            if (conn[p] && !frc[p]) hit = 1;
        end
        if (!rst_n)    model_pend <= 0;
        else if (hit)  model_pend <= 1;
        else if (ack)  model_pend <= 0;
    end

    task automatic check(input string tag);
        bit exp_irq;
        exp_irq = model_pend && gen;
        n_chk++;
        if (pending !== model_pend || irq !== exp_irq) begin
            n_fail++;
            $display("FAIL %s: pending=%b irq=%b expected pending=%b irq=%b",
                     tag, pending, irq, model_pend, exp_irq);
        end
    endtask

    task automatic clear_pulses();
        conn = '0; bab = '0; res = '0; ack = 1'b0;
    endtask

    // one cycle: inputs set after a falling edge, result read at the next
    task automatic cyc(input string tag);
        @(negedge clk);
        check(tag);
        clear_pulses();
    endtask

    // drain any pending flag so the next step starts from idle
    task automatic drain();
        clear_pulses(); ack = 1'b1;
        cyc("R8");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check("R1");
        rst_n = 1'b1; gen = 1'b1;
        cyc("R1");

        // R2: enabled babble on each port
        for (int p = 0; p < NP; p++) begin
            en = '0; en[p] = 1'b1; bab[p] = 1'b1;
            cyc("R2");
            drain();
        end
        // R3: disabled babble ignored
        for (int p = 0; p < NP; p++) begin
            en = ~('0 | (1 << p)); bab[p] = 1'b1;
            cyc("R3");
        end
        // R4: resume enabled and disabled
        en = 4'b0100; res = 4'b1011;
        cyc("R4");
        res = 4'b0100;
        cyc("R4");
        drain();
        // R5: attachment change with enables off
        en = '0; frc = '0; conn = 4'b1000;
        cyc("R5");
        drain();
        // R6: forced port drops attachment change
        frc = 4'b0010; conn = 4'b0010;
        cyc("R6");
        conn = 4'b0001;
        cyc("R5");
        drain();
        // R7: several ports and kinds at once
        en = 4'b1111; frc = 4'b0000; bab = 4'b0001; res = 4'b0100; conn = 4'b1000;
        cyc("R7");
        // R8: hold without ack, then clear, then ack while idle
        cyc("R8");
        cyc("R8");
        drain();
        ack = 1'b1;
        cyc("R8");
        // R9: event with ack in the same cycle
        res = 4'b0010;
        cyc("R7");
        res = 4'b0001; ack = 1'b1;
        cyc("R9");
        bab = 4'b1000; ack = 1'b1;
        cyc("R9");
        drain();
        // R10: gate off keeps pending, gate on restores request
        gen = 1'b0; conn = 4'b0100;
        cyc("R10");
        cyc("R10");
        gen = 1'b1;
        cyc("R10");
        drain();

        // long pseudo-random run against the model
        for (int i = 0; i < 3000; i++) begin
            en   = NP'($urandom);
            frc  = NP'($urandom);
            conn = ($urandom_range(0, 3) == 0) ? NP'($urandom) : '0;
            bab  = ($urandom_range(0, 3) == 0) ? NP'($urandom) : '0;
            res  = ($urandom_range(0, 3) == 0) ? NP'($urandom) : '0;
            ack  = ($urandom_range(0, 2) == 0);
            gen  = ($urandom_range(0, 3) != 0);
            cyc("R7");
        end
        finish_run();
    end

endmodule